// File: doc/BRIEF.md
# Selectable UART Core Clock Divider

This block derives the UART core clock from a fast reference clock. A 3-bit select code chooses one of eight fixed, non-uniform divide ratios. The block produces a clock-enable pulse train at the divided rate: one reference-cycle-wide pulse per output period. Downstream logic treats each pulse as one core clock cycle.

The divider has its own synchronous reset, which is the only time the select code is taken in, and an enable that stops the pulse train. A bypass input replaces the divided pulses with a pulse on every reference cycle. A ready flag rises once the divided clock has run long enough to be trusted. The flag drops at once whenever the divider is reset or disabled.

Top module: `uclk_div_core`

## Requirements
- R1: The latched select code maps to a divide ratio N as follows: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 6, code 4 gives 8, code 5 gives 16, code 6 gives 24 and code 7 gives 32. In any window of 64 consecutive running cycles that starts at release, `tick` is high in exactly floor(64/N) cycles.
- R2: A "running" cycle is one with `div_rst` low and `div_en` high. With `byp_sel` low, `tick` is high in the N-th running cycle after release and every N cycles after that, and it is low in all other cycles.
- R3: With ratio 1 (code 0), `tick` is high in every running cycle.
- R4: `div_sel` is sampled on each clock edge while `div_rst` is high. Changes to it while `div_rst` is low have no effect on the pulse spacing.
- R5: While `div_rst` is high and `byp_sel` is low, `tick` is low. After `div_rst` is released, counting restarts from the start of a period.
- R6: While `div_en` is low and `byp_sel` is low, `tick` is low. When `div_en` is raised again, counting restarts from the start of a period.
- R7: While `byp_sel` is high and `rst_n` is high, `tick` is high in every cycle, whatever the state of reset, enable and select.
- R8: `ready` is high in a running cycle once 20 divided pulses have occurred since the run began. It is low in any cycle where `div_rst` is high or `div_en` is low, and the pulse count starts again from zero after such a cycle. Bypass does not affect the count.
- R9: While `rst_n` is low, `tick` and `ready` are low. The latched code returns to 0, which gives ratio 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| div_rst | input | 1 | Synchronous divider reset; select code is taken in while high |
| div_en | input | 1 | Divider enable |
| byp_sel | input | 1 | High: pass the reference (tick every cycle) |
| div_sel | input | 3 | Divide ratio select code |
| tick | output | 1 | Divided clock-enable pulse |
| ready | output | 1 | Divided clock has run 20 periods |

## Verification
The case of interest is the cycle in which a divided pulse, including the twentieth pulse that would raise `ready`, falls in the same cycle as a rise of `div_rst` or a drop of `div_en`. The bench provokes it by configuring ratio 2 and counting cycles from release, so that the disable or reset lands exactly on a pulse cycle. A behavioural model decides every cycle whether the pulse is cut and whether the ready count restarts, and the design's outputs are compared against it.

// File: rtl/uclk_div_pkg.sv
package uclk_div_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 32;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  // divide ratio minus one for each select code
  function automatic logic [CNT_W-1:0] ratio_m1_of(input logic [SEL_W-1:0] code);
    logic [CNT_W:0] n;
    case (code)
      3'd0: n = 1;
      3'd1: n = 2;
      3'd2: n = 4;
      3'd3: n = 6;
      3'd4: n = 8;
      3'd5: n = 16;
      3'd6: n = 24;
      default: n = 32;
    endcase
    return CNT_W'(n - 1'b1);
  endfunction
endpackage

// File: rtl/uclk_div_sel.sv
module uclk_div_sel
  import uclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rst,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] ratio_m1
);
  logic [SEL_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (div_rst) code_q <= sel;
  end

  assign ratio_m1 = ratio_m1_of(code_q);

  // R4: code frozen outside divider reset
  p_code_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_rst |=> $stable(code_q));
endmodule

// File: rtl/uclk_div_count.sv
module uclk_div_count
  import uclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio_m1,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;

  assign pulse = run && (cnt == ratio_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || pulse)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R2: reload to period start after each pulse
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (cnt == '0));
  // R2: phase never beyond the period
  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ratio_m1);
  // R3: ratio one pulses every running cycle
  p_ratio_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ratio_m1 == '0) |-> pulse);
  // R6: stopped divider restarts from zero
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/uclk_div_ready.sv
module uclk_div_ready #(
  parameter int WAIT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pulse,
  output logic ready
);
  localparam int RW = $clog2(WAIT_CYC + 1);
  localparam logic [RW-1:0] FULL = RW'(WAIT_CYC);

  logic [RW-1:0] seen;
  logic          full;

  assign full  = (seen == FULL);
  assign ready = run && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seen <= '0;
    else if (!run)           seen <= '0;
    else if (pulse && !full) seen <= seen + 1'b1;
  end

  // R8: ready only rises right after a divided pulse
  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pulse));
  // R8: a stop clears progress
  p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (seen == '0));
endmodule

// File: rtl/uclk_div_core.sv
module uclk_div_core
  import uclk_div_pkg::*;
#(
  parameter int WAIT_CYC = 20
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             div_rst,
  input  logic             div_en,
  input  logic             byp_sel,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick,
  output logic             ready
);
  logic             run;
  logic             div_pulse;
  logic [CNT_W-1:0] ratio_m1;

  assign run = !div_rst && div_en;

  uclk_div_sel u_sel (
    .clk(clk_ref), .rst_n(rst_n), .div_rst(div_rst),
    .sel(div_sel), .ratio_m1(ratio_m1)
  );

  uclk_div_count u_cnt (
    .clk(clk_ref), .rst_n(rst_n), .run(run),
    .ratio_m1(ratio_m1), .pulse(div_pulse)
  );

  uclk_div_ready #(.WAIT_CYC(WAIT_CYC)) u_rdy (
    .clk(clk_ref), .rst_n(rst_n), .run(run),
    .pulse(div_pulse), .ready(ready)
  );

  assign tick = rst_n && (byp_sel || div_pulse);

  // R7: bypass passes every reference cycle
  p_bypass_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    byp_sel |-> tick);
  // R5: quiet in divider reset
  p_rst_quiet_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (div_rst && !byp_sel) |-> !tick);
  // R8: ready never with the divider stopped
  p_ready_run_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (div_rst || !div_en) |-> !ready);
endmodule

// File: tb/uclk_div_core_bench.sv
module uclk_div_core_bench;
  logic clk = 0;
  logic rst_n = 0, div_rst = 1, div_en = 0, byp_sel = 0;
  logic [2:0] div_sel = 0;
  logic tick, ready;

  always #10 clk = ~clk;  // 50 MHz

  uclk_div_core u_uclk_div_core (
    .clk_ref(clk), .rst_n(rst_n), .div_rst(div_rst), .div_en(div_en),
    .byp_sel(byp_sel), .div_sel(div_sel), .tick(tick), .ready(ready)
  );

  int compared = 0, mismatched = 0, cycles = 0, ticks_seen = 0;
  string tag = "R9";
  int m_code = 0, m_ph = 0, m_pulses = 0;
  bit done = 0;

  function automatic int ratio_tab(int c);
    int t[8] = '{1, 2, 4, 6, 8, 16, 24, 32};
    return t[c];
  endfunction

  function automatic bit m_pulse();
    return !div_rst && div_en && (m_ph == ratio_tab(m_code) - 1);
  endfunction

  task automatic check(string t, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // model update on the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_ph = 0; m_pulses = 0;
    end else begin
      bit p;
      p = m_pulse();
      if (!(!div_rst && div_en)) begin m_ph = 0; m_pulses = 0; end
      else if (p) begin m_ph = 0; m_pulses++; end
      else m_ph++;
      if (div_rst) m_code = div_sel;
    end
  end

  // compare away from the edge
  always @(negedge clk) begin
    int et, er;
    et = rst_n && (byp_sel || m_pulse());
    er = rst_n && !div_rst && div_en && (m_pulses >= 20);
    check(tag, tick, et, "tick");
    check(tag, ready, er, "ready");
    if (tick) ticks_seen++;
    cycles++;
    if (cycles > 100000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic configure(int code);
    div_rst = 1; div_sel = 3'(code); step(2);
    div_rst = 0; div_en = 1;
  endtask

  initial begin
    tag = "R9"; byp_sel = 1; div_en = 1; div_rst = 0;
    step(4);
    check("R9", tick, 0, "tick in reset");
    check("R9", ready, 0, "ready in reset");
    byp_sel = 0; rst_n = 1;
    step(3);          // code 0 after reset: ratio 1
    check("R9", tick, 1, "ratio 1 after reset");
    // sweep all codes
    for (int c = 0; c < 8; c++) begin
      tag = (c == 0) ? "R3" : "R2";
      configure(c);
      ticks_seen = 0;
      div_sel = 3'(~c);   // R4: ignored while running
      step(64);
      check("R1", ticks_seen, 64 / ratio_tab(c), "ticks in 64 cycles");
    end
    tag = "R4"; configure(3); div_sel = 3'd0; step(30);
    // ready on ratio 2
    tag = "R8"; configure(1); step(45);
    check("R8", ready, 1, "ready after 20 pulses");
    tag = "R6"; div_en = 0; step(1);
    check("R6", ready, 0, "ready after disable");
    check("R6", tick, 0, "tick while disabled");
    div_en = 1; step(10);
    // disable exactly on the 20th pulse
    tag = "R8"; configure(1); step(39); div_en = 0; step(1);
    div_en = 1; step(45);
    // divider reset on a pulse cycle
    tag = "R5"; configure(1); step(39); div_rst = 1; step(2);
    check("R5", tick, 0, "tick in divider reset");
    div_rst = 0; step(44);
    // bypass in all states
    tag = "R7"; byp_sel = 1; configure(4); step(30);
    div_rst = 1; step(3); div_rst = 0; div_en = 0; step(3);
    check("R7", tick, 1, "bypass while disabled");
    div_en = 1; step(200);
    byp_sel = 0; step(20);
    finish_run();
  end
endmodule